// File: doc/BRIEF.md
# Intra 4x4 Block Predictor

This block forms the sixteen predicted samples of a 4x4 luma block from the reconstructed pixels around it. The inputs are four pixels to the left, eight pixels above (four directly above and four above and to the right), the single corner pixel above and to the left, a 4-bit direction code and three neighbour-presence flags. The block supports nine prediction directions, including flat (DC) prediction. The DC value falls back to the neighbours that are present. When the above-right pixels are missing, copies of the last directly-above pixel stand in for them.

A request is accepted on a cycle where `start` and `ready` are both high. The block then streams the prediction as four 32-bit row words on consecutive cycles, top row first. An out-of-range direction code produces no rows and pulses an error flag instead. All three-tap smoothing is computed exactly, using only halving add and halving subtract steps on 8-bit values.

Top module: `intra4x4_pred`

## Requirements
- R1: After reset `ready` is 1 and `row_valid` and `mode_err` are 0. A start with a legal code is taken on a clock edge where `start` and `ready` are both high. `row_valid` is then high for exactly four consecutive cycles, starting the cycle after that edge, carrying rows 0, 1, 2 and 3. `row_last` is high only with row 3. `ready` is low while rows are being sent, and a `start` during that time has no effect.
- R2: Packing of the data ports. Pixel j of `left_px` is in bits 8j+7:8j and belongs to row j. Pixel i of `above_px` is in bits 8i+7:8i: i = 0..3 are directly above, and i = 4..7 are above-right. Column x of an output row is in bits 8x+7:8x of `row_data`.
- R3: Direction codes are 0 vertical, 1 horizontal, 2 DC, 3 down-left diagonal, 4 down-right diagonal, 5 vertical-right, 6 horizontal-down, 7 vertical-left and 8 horizontal-up. Code 0 copies above pixels 0..3 into every row. Code 1 fills row y with left pixel y.
- R4: Code 2 with both `avail_up` and `avail_left` high fills the block with (sum of above 0..3 + sum of left 0..3 + 4) >> 3.
- R5: Code 2 with only `avail_up` high gives (sum of above + 2) >> 2. With only `avail_left` high it gives (sum of left + 2) >> 2. With neither flag high it gives 128.
- R6: Every three-tap sample equals (a + 2b + c + 2) >> 2 exactly, including when the inputs are 0 or 255. Every two-tap sample equals (a + b + 1) >> 1.
- R7: Code 3 gives pixel (x,y) = filt(U[x+y], U[x+y+1], U[x+y+2]). The exception is (3,3), which is filt(U6, U7, U7).
- R8: For codes 3 and 7, when `avail_upright` is 0, above pixels 4..7 are replaced by copies of above pixel 3.
- R9: Code 4 filters along the down-right diagonal through the corner. Pixel (x,y) is filt(U[d-2], U[d-1], U[d]) for d = x-y > 0, filt(U0, corner, L0) on the main diagonal, and filt(L[-d-2], L[-d-1], L[-d]) for d < 0. An index of -1 selects the corner pixel.
- R10: Code 5 uses z = 2x-y and k = x-(y>>1). It gives avg(U[k-1], U[k]) for even z >= 0, filt(U[k-2], U[k-1], U[k]) for odd z > 0, filt(L0, corner, U0) for z = -1, and filt(L[y-1], L[y-2], L[y-3]) otherwise.
- R11: Code 6 uses z = 2y-x and k = y-(x>>1). It gives avg(L[k-1], L[k]) for even z >= 0, filt(L[k-2], L[k-1], L[k]) for odd z > 0, filt(L0, corner, U0) for z = -1, and filt(U[x-1], U[x-2], U[x-3]) otherwise.
- R12: Code 7 uses k = x+(y>>1). It gives avg(U[k], U[k+1]) on even rows and filt(U[k], U[k+1], U[k+2]) on odd rows.
- R13: Code 8 uses z = x+2y and k = y+(x>>1). It gives avg(L[k], L[k+1]) for even z < 5, filt(L[k], L[k+1], L[k+2]) for odd z < 5, filt(L2, L3, L3) for z = 5, and L3 for z > 5. The bottom row is therefore all L3.
- R14: A start with a code above 8 sends no rows. It raises `mode_err` for exactly the one cycle after the accepting edge, and `ready` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a prediction |
| mode | input | 4 | Direction code |
| avail_up | input | 1 | Above pixels present |
| avail_left | input | 1 | Left pixels present |
| avail_upright | input | 1 | Above-right pixels present |
| left_px | input | 32 | Left pixels 0..3 |
| above_px | input | 64 | Above pixels 0..7 |
| corner_px | input | 8 | Above-left corner pixel |
| ready | output | 1 | Idle, start will be taken |
| row_valid | output | 1 | Row word valid |
| row_last | output | 1 | Final row of the block |
| row_data | output | 32 | Predicted row, column 0 in low byte |
| mode_err | output | 1 | Out-of-range code pulse |

## Verification
The case hardest to reach from the ports is a new `start` arriving while a block is still streaming out. Its data must not disturb the rows in flight, and it must not queue a second block. The stimulus raises `start` with a different code in the middle of a burst, then watches the remaining rows and the idle cycle that follows. The availability fall-backs are reached by sweeping all eight flag combinations for every code over random pixels. Saturated all-0 and all-255 neighbour patterns exercise the signed halving steps at their extremes.

// File: rtl/intra4_pkg.sv
package intra4_pkg;
  localparam int PIX_W    = 8;
  localparam int BLK_N    = 4;
  localparam int ROW_W    = PIX_W * BLK_N;
  localparam int BLK_W    = ROW_W * BLK_N;
  localparam int EDGE_N   = 2 * BLK_N + 1;
  localparam int EDGE_W   = EDGE_N * PIX_W;
  localparam int UEXT_W   = 2 * ROW_W;
  localparam int SUM_W    = PIX_W + $clog2(2 * BLK_N) + 1;

  typedef logic [PIX_W-1:0] pix_t;

  localparam pix_t MID = pix_t'(1 << (PIX_W - 1));

  localparam logic [3:0] M_VERT = 4'd0;
  localparam logic [3:0] M_HORZ = 4'd1;
  localparam logic [3:0] M_DC   = 4'd2;
  localparam logic [3:0] M_DDL  = 4'd3;
  localparam logic [3:0] M_DDR  = 4'd4;
  localparam logic [3:0] M_VR   = 4'd5;
  localparam logic [3:0] M_HD   = 4'd6;
  localparam logic [3:0] M_VL   = 4'd7;
  localparam logic [3:0] M_HU   = 4'd8;
  localparam logic [3:0] MODE_MAX = M_HU;

  // floor((a+b)/2)
  function automatic pix_t hadd(pix_t a, pix_t b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PIX_W:1];
  endfunction

  // signed floor((a-b)/2), low byte kept
  function automatic pix_t hsub(pix_t a, pix_t b);
    logic signed [PIX_W+1:0] df;
    df = $signed({2'b00, a}) - $signed({2'b00, b});
    df = df >>> 1;
    return df[PIX_W-1:0];
  endfunction

  // (a + 2b + c + 2) >> 2 using halving steps only
  function automatic pix_t filt3(pix_t a, pix_t b, pix_t c);
    return hsub(hadd(a, c), ~b) + MID;
  endfunction

  // (a + b + 1) >> 1 using a halving subtract
  function automatic pix_t avg2(pix_t a, pix_t b);
    return hsub(a, ~b) + MID;
  endfunction

  function automatic pix_t byte_at(logic [EDGE_W-1:0] v, int k);
    int kk;
    kk = (k < 0) ? 0 : ((k > EDGE_N - 1) ? EDGE_N - 1 : k);
    return v[kk*PIX_W +: PIX_W];
  endfunction

  // edge vector: byte BLK_N is the corner, above to the high side, left to the low side
  function automatic pix_t up_px(logic [EDGE_W-1:0] e, int i);
    return byte_at(e, BLK_N + 1 + i);
  endfunction

  function automatic pix_t lf_px(logic [EDGE_W-1:0] e, int j);
    return byte_at(e, BLK_N - 1 - j);
  endfunction

  function automatic pix_t ux_px(logic [UEXT_W-1:0] ue, int i);
    return byte_at({{(EDGE_W-UEXT_W){1'b0}}, ue}, i);
  endfunction

  function automatic pix_t calc_pixel(logic [3:0] mode, int x, int y,
                                      logic [EDGE_W-1:0] e,
                                      logic [UEXT_W-1:0] ue, pix_t dcv);
    int   z, k;
    pix_t q;
    q = byte_at(e, BLK_N);
    unique case (mode)
      M_VERT: return up_px(e, x);
      M_HORZ: return lf_px(e, y);
      M_DC:   return dcv;
      M_DDL: begin
        if (x == BLK_N - 1 && y == BLK_N - 1)
          return filt3(ux_px(ue, 6), ux_px(ue, 7), ux_px(ue, 7));
        return filt3(ux_px(ue, x + y), ux_px(ue, x + y + 1), ux_px(ue, x + y + 2));
      end
      M_DDR: return filt3(byte_at(e, BLK_N - 1 + x - y), byte_at(e, BLK_N + x - y),
                          byte_at(e, BLK_N + 1 + x - y));
      M_VR: begin
        z = 2 * x - y;
        k = x - (y >> 1);
        if (z >= 0 && (z % 2) == 0) return avg2(up_px(e, k - 1), up_px(e, k));
        if (z > 0)                  return filt3(up_px(e, k - 2), up_px(e, k - 1), up_px(e, k));
        if (z == -1)                return filt3(lf_px(e, 0), q, up_px(e, 0));
        return filt3(lf_px(e, y - 1), lf_px(e, y - 2), lf_px(e, y - 3));
      end
      M_HD: begin
        z = 2 * y - x;
        k = y - (x >> 1);
        if (z >= 0 && (z % 2) == 0) return avg2(lf_px(e, k - 1), lf_px(e, k));
        if (z > 0)                  return filt3(lf_px(e, k - 2), lf_px(e, k - 1), lf_px(e, k));
        if (z == -1)                return filt3(lf_px(e, 0), q, up_px(e, 0));
        return filt3(up_px(e, x - 1), up_px(e, x - 2), up_px(e, x - 3));
      end
      M_VL: begin
        k = x + (y >> 1);
        if ((y % 2) == 0) return avg2(ux_px(ue, k), ux_px(ue, k + 1));
        return filt3(ux_px(ue, k), ux_px(ue, k + 1), ux_px(ue, k + 2));
      end
      M_HU: begin
        z = x + 2 * y;
        k = y + (x >> 1);
        if (z < 5 && (z % 2) == 0) return avg2(lf_px(e, k), lf_px(e, k + 1));
        if (z < 5)                 return filt3(lf_px(e, k), lf_px(e, k + 1), lf_px(e, k + 2));
        if (z == 5)                return filt3(lf_px(e, 2), lf_px(e, 3), lf_px(e, 3));
        return lf_px(e, 3);
      end
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/intra4_nbr_prep.sv
module intra4_nbr_prep
  import intra4_pkg::*;
(
  input  logic [ROW_W-1:0]  left_px,
  input  logic [UEXT_W-1:0] above_px,
  input  logic [PIX_W-1:0]  corner_px,
  input  logic              avail_upright,
  output logic [EDGE_W-1:0] edge_vec,
  output logic [UEXT_W-1:0] above_ext
);
  // low bytes: left pixels bottom-up, then corner, then the four above
  generate
    for (genvar j = 0; j < BLK_N; j++) begin : g_left
      assign edge_vec[(BLK_N-1-j)*PIX_W +: PIX_W] = left_px[j*PIX_W +: PIX_W];
    end
    for (genvar i = 0; i < BLK_N; i++) begin : g_up
      assign edge_vec[(BLK_N+1+i)*PIX_W +: PIX_W] = above_px[i*PIX_W +: PIX_W];
      assign above_ext[i*PIX_W +: PIX_W]          = above_px[i*PIX_W +: PIX_W];
      assign above_ext[(BLK_N+i)*PIX_W +: PIX_W]  = avail_upright
                                                    ? above_px[(BLK_N+i)*PIX_W +: PIX_W]
                                                    : above_px[(BLK_N-1)*PIX_W +: PIX_W];
    end
  endgenerate
  assign edge_vec[BLK_N*PIX_W +: PIX_W] = corner_px;
endmodule

// File: rtl/intra4_dc_calc.sv
module intra4_dc_calc
  import intra4_pkg::*;
(
  input  logic [ROW_W-1:0] left_px,
  input  logic [ROW_W-1:0] above_px,
  input  logic             avail_up,
  input  logic             avail_left,
  output pix_t             dc_val
);
  localparam int SH_ONE  = $clog2(BLK_N);
  localparam int SH_BOTH = SH_ONE + 1;

  logic [SUM_W-1:0] sum_up, sum_left, both;

  always_comb begin
    sum_up   = '0;
    sum_left = '0;
    for (int i = 0; i < BLK_N; i++) begin
      sum_up   = sum_up   + SUM_W'(above_px[i*PIX_W +: PIX_W]);
      sum_left = sum_left + SUM_W'(left_px[i*PIX_W +: PIX_W]);
    end
    both = sum_up + sum_left + SUM_W'(BLK_N);
    unique case ({avail_up, avail_left})
      2'b11:   dc_val = pix_t'(both >> SH_BOTH);
      2'b10:   dc_val = pix_t'((sum_up + SUM_W'(BLK_N / 2)) >> SH_ONE);
      2'b01:   dc_val = pix_t'((sum_left + SUM_W'(BLK_N / 2)) >> SH_ONE);
      default: dc_val = MID;
    endcase
  end
endmodule

// File: rtl/intra4_pix_grid.sv
module intra4_pix_grid
  import intra4_pkg::*;
(
  input  logic [3:0]        mode,
  input  logic [EDGE_W-1:0] edge_vec,
  input  logic [UEXT_W-1:0] above_ext,
  input  pix_t              dc_val,
  output logic [BLK_W-1:0]  blk
);
  generate
    for (genvar gy = 0; gy < BLK_N; gy++) begin : g_row
      for (genvar gx = 0; gx < BLK_N; gx++) begin : g_col
        assign blk[(gy*BLK_N+gx)*PIX_W +: PIX_W] =
          calc_pixel(mode, gx, gy, edge_vec, above_ext, dc_val);
      end
    end
  endgenerate
endmodule

// File: rtl/intra4_row_seq.sv
module intra4_row_seq
  import intra4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             err_in,
  input  logic [BLK_W-1:0] blk,
  output logic             ready,
  output logic             row_valid,
  output logic             row_last,
  output logic [ROW_W-1:0] row_data,
  output logic             mode_err
);
  localparam int BEAT_W = $clog2(BLK_N);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BLK_N - 1);

  logic [BLK_W-1:0]  blk_q;
  logic [BEAT_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q     <= '0;
      beat      <= '0;
      row_valid <= 1'b0;
      mode_err  <= 1'b0;
    end else begin
      mode_err <= err_in;
      if (load) begin
        blk_q     <= blk;
        beat      <= '0;
        row_valid <= 1'b1;
      end else if (row_valid) begin
        if (beat == LAST_BEAT) row_valid <= 1'b0;
        else                   beat      <= beat + 1'b1;
      end
    end
  end

  assign ready    = ~row_valid;
  assign row_last = row_valid && (beat == LAST_BEAT);
  assign row_data = blk_q[beat*ROW_W +: ROW_W];
endmodule

// File: rtl/intra4x4_pred.sv
module intra4x4_pred
  import intra4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       mode,
  input  logic             avail_up,
  input  logic             avail_left,
  input  logic             avail_upright,
  input  logic [31:0]      left_px,
  input  logic [63:0]      above_px,
  input  logic [7:0]       corner_px,
  output logic             ready,
  output logic             row_valid,
  output logic             row_last,
  output logic [31:0]      row_data,
  output logic             mode_err
);
  // named events for the checker
  logic start_acc, mode_legal, row_load, err_evt;
  assign start_acc  = start && ready;
  assign mode_legal = (mode <= MODE_MAX);
  assign row_load   = start_acc && mode_legal;
  assign err_evt    = start_acc && !mode_legal;

  logic [EDGE_W-1:0] edge_vec;
  logic [UEXT_W-1:0] above_ext;
  pix_t              dc_val;
  logic [BLK_W-1:0]  blk;

  intra4_nbr_prep u_prep (
    .left_px       (left_px),
    .above_px      (above_px),
    .corner_px     (corner_px),
    .avail_upright (avail_upright),
    .edge_vec      (edge_vec),
    .above_ext     (above_ext)
  );

  intra4_dc_calc u_dc (
    .left_px    (left_px),
    .above_px   (above_px[ROW_W-1:0]),
    .avail_up   (avail_up),
    .avail_left (avail_left),
    .dc_val     (dc_val)
  );

  intra4_pix_grid u_grid (
    .mode      (mode),
    .edge_vec  (edge_vec),
    .above_ext (above_ext),
    .dc_val    (dc_val),
    .blk       (blk)
  );

  intra4_row_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (row_load),
    .err_in    (err_evt),
    .blk       (blk),
    .ready     (ready),
    .row_valid (row_valid),
    .row_last  (row_last),
    .row_data  (row_data),
    .mode_err  (mode_err)
  );
endmodule

// File: rtl/intra4x4_pred_chk.sv
module intra4x4_pred_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  mode,
  input logic        avail_up,
  input logic        avail_left,
  input logic [31:0] above_lo,
  input logic        ready,
  input logic        row_valid,
  input logic        row_last,
  input logic [31:0] row_data,
  input logic        mode_err
);
  logic       acc;
  logic [1:0] beat_cnt;
  assign acc = start && ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         beat_cnt <= '0;
    else if (row_valid) beat_cnt <= row_last ? 2'd0 : beat_cnt + 2'd1;
    else                beat_cnt <= '0;
  end

  AST_START_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode <= 4'd8) |=> (row_valid && !mode_err)); // R1
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !row_last) |=> row_valid); // R1
  AST_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    row_last |-> (beat_cnt == 2'd3)); // R1
  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    row_last |=> !row_valid); // R1
  AST_ILLEGAL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode > 4'd8) |=> (mode_err && !row_valid)); // R14
  AST_ERR_NO_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !row_valid); // R14
  AST_VERT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 4'd0) |=> (row_data == $past(above_lo))); // R3
  AST_DC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 4'd2 && !avail_up && !avail_left) |=> (row_data == 32'h80808080)); // R5
endmodule

bind intra4x4_pred intra4x4_pred_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .mode       (mode),
  .avail_up   (avail_up),
  .avail_left (avail_left),
  .above_lo   (above_px[31:0]),
  .ready      (ready),
  .row_valid  (row_valid),
  .row_last   (row_last),
  .row_data   (row_data),
  .mode_err   (mode_err)
);

// File: tb/tb_intra4x4_pred.sv
module tb_intra4x4_pred;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, avail_up, avail_left, avail_upright;
  logic [3:0]  mode;
  logic [31:0] left_px;
  logic [63:0] above_px;
  logic [7:0]  corner_px;
  logic        ready, row_valid, row_last, mode_err;
  logic [31:0] row_data;

  intra4x4_pred dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .avail_up(avail_up), .avail_left(avail_left), .avail_upright(avail_upright),
    .left_px(left_px), .above_px(above_px), .corner_px(corner_px),
    .ready(ready), .row_valid(row_valid), .row_last(row_last),
    .row_data(row_data), .mode_err(mode_err)
  );

  int n_chk = 0, n_bad = 0;
  int rl [0:3];
  int ru [0:7];
  int rue[0:7];
  int rq;
  logic [31:0] seed = 32'h1234_5679;

  // stimulus table: {mode[3:0], avail{upright,left,up}[2:0], pattern[1:0]}
  localparam int NVEC = 12;
  localparam logic [8:0] VEC [0:NVEC-1] = '{
    {4'd0, 3'b111, 2'd3}, {4'd1, 3'b111, 2'd3}, {4'd2, 3'b011, 2'd2},
    {4'd2, 3'b001, 2'd2}, {4'd3, 3'b111, 2'd2}, {4'd3, 3'b011, 2'd3},
    {4'd4, 3'b111, 2'd1}, {4'd5, 3'b111, 2'd2}, {4'd6, 3'b111, 2'd3},
    {4'd7, 3'b011, 2'd2}, {4'd8, 3'b111, 2'd2}, {4'd4, 3'b111, 2'd3}
  };

  function automatic int rnd8();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'(seed[7:0]);
  endfunction

  function automatic int f3(int a, int b, int c);
    return (a + 2 * b + c + 2) >> 2;
  endfunction

  function automatic int a2(int a, int b);
    return (a + b + 1) >> 1;
  endfunction

  function automatic int uu(int i);
    if (i < 0) return rq;
    return ru[i];
  endfunction

  function automatic int ll(int j);
    if (j < 0) return rq;
    return rl[j];
  endfunction

  function automatic int ref_px(int m, int av, int x, int y);
    int su, sl, z, k;
    su = ru[0] + ru[1] + ru[2] + ru[3];
    sl = rl[0] + rl[1] + rl[2] + rl[3];
    case (m)
      0: return ru[x];
      1: return rl[y];
      2: begin
        if ((av & 3) == 3) return (su + sl + 4) >> 3;
        if ((av & 3) == 1) return (su + 2) >> 2;
        if ((av & 3) == 2) return (sl + 2) >> 2;
        return 128;
      end
      3: begin
        if (x == 3 && y == 3) return f3(rue[6], rue[7], rue[7]);
        return f3(rue[x+y], rue[x+y+1], rue[x+y+2]);
      end
      4: begin
        if (x > y) return f3(uu(x-y-2), uu(x-y-1), uu(x-y));
        if (x < y) return f3(ll(y-x-2), ll(y-x-1), ll(y-x));
        return f3(ru[0], rq, rl[0]);
      end
      5: begin
        z = 2 * x - y; k = x - y / 2;
        if (z >= 0 && z % 2 == 0) return a2(uu(k-1), uu(k));
        if (z > 0) return f3(uu(k-2), uu(k-1), uu(k));
        if (z == -1) return f3(rl[0], rq, ru[0]);
        return f3(ll(y-1), ll(y-2), ll(y-3));
      end
      6: begin
        z = 2 * y - x; k = y - x / 2;
        if (z >= 0 && z % 2 == 0) return a2(ll(k-1), ll(k));
        if (z > 0) return f3(ll(k-2), ll(k-1), ll(k));
        if (z == -1) return f3(rl[0], rq, ru[0]);
        return f3(uu(x-1), uu(x-2), uu(x-3));
      end
      7: begin
        k = x + y / 2;
        if (y % 2 == 0) return a2(rue[k], rue[k+1]);
        return f3(rue[k], rue[k+1], rue[k+2]);
      end
      default: begin
        z = x + 2 * y; k = y + x / 2;
        if (z < 5 && z % 2 == 0) return a2(rl[k], rl[k+1]);
        if (z < 5) return f3(rl[k], rl[k+1], rl[k+2]);
        if (z == 5) return f3(rl[2], rl[3], rl[3]);
        return rl[3];
      end
    endcase
  endfunction

  function automatic logic [31:0] exp_row(int m, int av, int y);
    logic [31:0] w;
    for (int x = 0; x < 4; x++) w[8*x +: 8] = 8'(ref_px(m, av, x, y));
    return w;
  endfunction

  function automatic string tag_of(int m, int av);
    case (m)
      0, 1: return "R3";
      2: return ((av & 3) == 3) ? "R4" : "R5";
      3: return (av & 4) ? "R7" : "R8";
      4: return "R9";
      5: return "R10";
      6: return "R11";
      7: return (av & 4) ? "R12" : "R8";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_pat(int pat);
    for (int j = 0; j < 4; j++)
      rl[j] = (pat == 0) ? rnd8() : (pat == 1) ? 0 : (pat == 2) ? 255 : 250 - 40 * j;
    for (int i = 0; i < 8; i++)
      ru[i] = (pat == 0) ? rnd8() : (pat == 1) ? 0 : (pat == 2) ? 255 : 10 + 30 * i;
    rq = (pat == 0) ? rnd8() : (pat == 1) ? 255 : (pat == 2) ? 0 : 128;
  endtask

  task automatic drive(int m, int av);
    for (int j = 0; j < 4; j++) left_px[8*j +: 8] = 8'(rl[j]);
    for (int i = 0; i < 8; i++) begin
      above_px[8*i +: 8] = 8'(ru[i]);
      rue[i] = (i < 4 || (av & 4) != 0) ? ru[i] : ru[3];
    end
    corner_px     = 8'(rq);
    mode          = 4'(m);
    avail_up      = (av & 1) != 0;
    avail_left    = (av & 2) != 0;
    avail_upright = (av & 4) != 0;
  endtask

  task automatic run_one(int m, int av, string tag);
    drive(m, av);
    @(negedge clk);
    chk(ready == 1'b1, "R1", {31'd0, ready}, 32'd1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int y = 0; y < 4; y++) begin
      chk(row_valid == 1'b1, "R1", {31'd0, row_valid}, 32'd1);
      chk(row_last == (y == 3), "R1", {31'd0, row_last}, (y == 3) ? 32'd1 : 32'd0);
      chk(row_data == exp_row(m, av, y), tag, row_data, exp_row(m, av, y));
      @(negedge clk);
    end
    chk(row_valid == 1'b0, "R1", {31'd0, row_valid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1: watchdog expired, actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = '0;
    avail_up = 1'b0; avail_left = 1'b0; avail_upright = 1'b0;
    left_px = '0; above_px = '0; corner_px = '0;
    repeat (3) @(negedge clk);
    // reset state, R1 and R14
    chk(ready == 1'b1, "R1", {31'd0, ready}, 32'd1);
    chk(row_valid == 1'b0, "R1", {31'd0, row_valid}, 32'd0);
    chk(mode_err == 1'b0, "R14", {31'd0, mode_err}, 32'd0);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      load_pat(int'(VEC[v][1:0]));
      run_one(int'(VEC[v][8:5]), int'(VEC[v][4:2]),
              tag_of(int'(VEC[v][8:5]), int'(VEC[v][4:2])));
    end

    // R2 byte packing with literal words
    rl = '{8'h11, 8'h22, 8'h33, 8'h44};
    ru = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    rq = 8'h99;
    drive(0, 7);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    chk(row_data == 32'h44332211, "R2", row_data, 32'h44332211);
    repeat (4) @(negedge clk);
    drive(1, 7);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(row_data == 32'h11111111, "R2", row_data, 32'h11111111);
    @(negedge clk);
    chk(row_data == 32'h22222222, "R2", row_data, 32'h22222222);
    repeat (3) @(negedge clk);

    // R6 filter at saturated inputs: corner 255, everything else 0
    load_pat(1);
    drive(4, 7);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(row_data == 32'h00004080, "R6", row_data, 32'h00004080);
    @(negedge clk);
    chk(row_data == 32'h00408040, "R6", row_data, 32'h00408040);
    repeat (3) @(negedge clk);
    load_pat(2);
    run_one(5, 7, "R6");

    // R1 start while busy is ignored
    load_pat(0);
    drive(0, 7);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(row_data == exp_row(0, 7, 0), "R1", row_data, exp_row(0, 7, 0));
    @(negedge clk);
    chk(ready == 1'b0, "R1", {31'd0, ready}, 32'd0);
    mode = 4'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(row_data == exp_row(0, 7, 2), "R1", row_data, exp_row(0, 7, 2));
    @(negedge clk);
    chk(row_last == 1'b1, "R1", {31'd0, row_last}, 32'd1);
    @(negedge clk);
    chk(row_valid == 1'b0, "R1", {31'd0, row_valid}, 32'd0);
    @(negedge clk);
    chk(row_valid == 1'b0, "R1", {31'd0, row_valid}, 32'd0);

    // R14 illegal codes
    for (int m = 9; m < 16; m += 6) begin
      mode = 4'(m); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(mode_err == 1'b1, "R14", {31'd0, mode_err}, 32'd1);
      chk(row_valid == 1'b0, "R14", {31'd0, row_valid}, 32'd0);
      chk(ready == 1'b1, "R14", {31'd0, ready}, 32'd1);
      @(negedge clk);
      chk(mode_err == 1'b0, "R14", {31'd0, mode_err}, 32'd0);
      chk(row_valid == 1'b0, "R14", {31'd0, row_valid}, 32'd0);
    end

    // R1 reset during a burst
    drive(2, 3);
    start = 1'b1; @(negedge clk); start = 1'b0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk(row_valid == 1'b0, "R1", {31'd0, row_valid}, 32'd0);

    // full sweep of codes and availability over random pixels (R3..R13, R8)
    for (int m = 0; m < 9; m++)
      for (int av = 0; av < 8; av++) begin
        load_pat(0);
        run_one(m, av, tag_of(m, av));
      end

    finish_run();
  end
endmodule